// File: doc/BRIEF.md
# Redistributor Power and Wake Handshake Controller

This block sits beside one per-core interrupt redistributor and owns two small control registers on a 32-bit register bus. The first register carries the core's sleep request together with a status flag that shows whether everything downstream has quiesced. The second carries this redistributor's local power-down request and a pair of status bits that describe the power state of the group it belongs to.

Status never follows a request at once. A sleep or wake request is acknowledged only after a configurable quiesce delay. A group power-down or power-up passes through a visible window, during which exactly one of the two group bits is set. A group powers off only when the redistributor that requests power-down is the last powered member, which the `sole_member` input tells the block. Software must obey an ordering rule on the sleep request. A write that breaks the rule is dropped and raises a sticky error flag that clears when read. Writes to the power register while the group is changing state are dropped, so software retries its power-on write until the local request bit reads back 0.

Top module: `rdpw_ctrl`

## Requirements
- R1: After reset the sleep register reads 0x0000_0006 (sleep request 1, quiesced 1, error 0), the power register reads 0 and `grp_busy` is 0.
- R2: The sleep register sits at offset 0x14 with the sleep request at bit 1 (read/write), the quiesced status at bit 2 (read-only) and the error flag at bit 31. The power register sits at offset 0x24 with the local power-down request at bit 0 (read/write), group power-down at bit 1 and group off at bit 2 (both read-only). Any other offset reads 0, and writes to read-only bits have no effect.
- R3: Clearing the sleep request while quiesced reads 1 is accepted, and quiesced falls to 0 exactly WAKE_LAT cycles after the write edge.
- R4: Setting the sleep request while quiesced reads 0 is accepted, and quiesced rises to 1 exactly WAKE_LAT cycles after the write edge.
- R5: A write that sets the sleep request while quiesced is 1, or clears it while quiesced is 0, leaves the request unchanged and sets the error flag. A write that does not change the request never sets the error flag.
- R6: A read of offset 0x14 returns the error flag and clears it on that clock edge. The next read returns 0 in bit 31 unless a new violation occurred.
- R7: Writing 1 to the local request while `sole_member` is 1 and the group is powered sets group power-down in the same edge. Group off follows exactly GRP_LAT cycles later, and `grp_busy` is 1 for the whole window.
- R8: Writing 1 to the local request while `sole_member` is 0 sets only the local bit and leaves both group bits at 0.
- R9: A write to the power register while group power-down and group off differ is ignored, and the local request keeps its old value.
- R10: Writing 0 to the power register clears the local request. If the group is off, group power-down clears in the same edge and group off clears GRP_LAT cycles later.
- R11: `grp_busy` is 1 exactly when group power-down and group off differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives clear-on-read) |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current `bus_addr` (combinational) |
| sole_member | input | 1 | This redistributor is the last powered member of its group |
| grp_busy | output | 1 | Group power state is in transition |

## Verification
The assertions assume single-cycle bus strobes whose address and data are valid in the same cycle. They also assume that `sole_member` is a level that stays steady around a power-register write. The bench drives all inputs on the falling edge and holds `sole_member` constant across each write. The latency properties count cycles with checker counters instead of deep `$past`, so they assume every request change starts from a settled state. The bench reaches an unsettled state only through the deliberately illegal writes, and the design rejects those.

// File: rtl/rdpw_pkg.sv
package rdpw_pkg;
  localparam int DW = 32;

  // Register offsets and field positions
  localparam logic [7:0] WAKE_OFS = 8'h14;
  localparam logic [7:0] PWR_OFS  = 8'h24;
  localparam int B_SLEEP   = 1;
  localparam int B_QUIET   = 2;
  localparam int B_ERR     = 31;
  localparam int B_LPD     = 0;
  localparam int B_GPD     = 1;
  localparam int B_GOFF    = 2;

  // A sleep-request change is legal only against the opposite quiesced state
  function automatic logic wake_change_legal(input logic new_sleep, input logic quiet);
    return new_sleep ? !quiet : quiet;
  endfunction

  function automatic logic group_moving(input logic gpd, input logic goff);
    return gpd ^ goff;
  endfunction

  function automatic logic [DW-1:0] pack_wake(input logic err, input logic quiet,
                                               input logic sleep);
    logic [DW-1:0] v;
    v = '0;
    v[B_ERR]   = err;
    v[B_QUIET] = quiet;
    v[B_SLEEP] = sleep;
    return v;
  endfunction

  function automatic logic [DW-1:0] pack_pwr(input logic lpd, input logic gpd,
                                              input logic goff);
    logic [DW-1:0] v;
    v = '0;
    v[B_LPD]  = lpd;
    v[B_GPD]  = gpd;
    v[B_GOFF] = goff;
    return v;
  endfunction
endpackage

// File: rtl/rdpw_lag_timer.sv
module rdpw_lag_timer #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic done
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!busy || done)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rdpw_wake_fsm.sv
module rdpw_wake_fsm
  import rdpw_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic new_sleep,
  input  logic rd_clr,
  output logic sleep,
  output logic quiet,
  output logic err,
  output logic rejected
);
  logic change, accept, pending, settle;

  assign change   = wr && (new_sleep != sleep);
  assign accept   = change && wake_change_legal(new_sleep, quiet);
  assign rejected = change && !accept;
  assign pending  = sleep != quiet;

  rdpw_lag_timer #(.LAT(LAT)) u_lag (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (pending),
    .done  (settle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep <= 1'b1;
      quiet <= 1'b1;
      err   <= 1'b0;
    end else begin
      if (accept) sleep <= new_sleep;
      if (settle) quiet <= sleep;
      if (rejected)    err <= 1'b1;
      else if (rd_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/rdpw_power_seq.sv
module rdpw_power_seq
  import rdpw_pkg::*;
#(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic new_lpd,
  input  logic sole,
  output logic lpd,
  output logic gpd,
  output logic goff,
  output logic moving,
  output logic accepted
);
  logic settle, start_down, start_up;

  assign moving     = group_moving(gpd, goff);
  assign accepted   = wr && !moving;
  assign start_down = accepted && new_lpd && sole && !gpd;
  assign start_up   = accepted && !new_lpd && gpd;

  rdpw_lag_timer #(.LAT(LAT)) u_lag (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (moving),
    .done  (settle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpd  <= 1'b0;
      gpd  <= 1'b0;
      goff <= 1'b0;
    end else begin
      if (accepted)   lpd <= new_lpd;
      if (start_down) gpd <= 1'b1;
      else if (start_up) gpd <= 1'b0;
      if (settle) goff <= gpd;
    end
  end
endmodule

// File: rtl/rdpw_ctrl.sv
module rdpw_ctrl
  import rdpw_pkg::*;
#(
  parameter int WAKE_LAT = 8,
  parameter int GRP_LAT  = 16,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sole_member,
  output logic          grp_busy
);
  // Decoded bus events, kept as named wires for the checker
  logic wake_sel, pwr_sel, wake_wr, wake_rd, pwr_wr;
  logic sleep, quiet, err, wake_rejected;
  logic lpd, gpd, goff, pwr_accepted;
  logic wdata_unused;

  assign wake_sel = bus_addr == AW'(WAKE_OFS);
  assign pwr_sel  = bus_addr == AW'(PWR_OFS);
  assign wake_wr  = bus_wr && wake_sel;
  assign wake_rd  = bus_rd && wake_sel;
  assign pwr_wr   = bus_wr && pwr_sel;
  assign wdata_unused = ^{bus_wdata[DW-1:B_SLEEP+1], wake_rejected, pwr_accepted};

  rdpw_wake_fsm #(.LAT(WAKE_LAT)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wake_wr),
    .new_sleep (bus_wdata[B_SLEEP]),
    .rd_clr    (wake_rd),
    .sleep     (sleep),
    .quiet     (quiet),
    .err       (err),
    .rejected  (wake_rejected)
  );

  rdpw_power_seq #(.LAT(GRP_LAT)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (pwr_wr),
    .new_lpd  (bus_wdata[B_LPD]),
    .sole     (sole_member),
    .lpd      (lpd),
    .gpd      (gpd),
    .goff     (goff),
    .moving   (grp_busy),
    .accepted (pwr_accepted)
  );

  always_comb begin
    bus_rdata = '0;
    if (wake_sel)     bus_rdata = pack_wake(err, quiet, sleep);
    else if (pwr_sel) bus_rdata = pack_pwr(lpd, gpd, goff);
  end
endmodule

// File: rtl/rdpw_ctrl_chk.sv
module rdpw_ctrl_chk #(
  parameter int WAKE_LAT = 8,
  parameter int GRP_LAT  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic quiet,
  input logic err,
  input logic lpd,
  input logic gpd,
  input logic goff,
  input logic grp_busy,
  input logic wake_wr,
  input logic wake_rd,
  input logic pwr_wr,
  input logic sole_member
);
  localparam int WCW = $clog2(WAKE_LAT + 2);
  localparam int GCW = $clog2(GRP_LAT + 2);

  logic [WCW-1:0] wake_cnt;
  logic [GCW-1:0] grp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_cnt <= '0;
      grp_cnt  <= '0;
    end else begin
      if (sleep == quiet) wake_cnt <= '0;
      else if (wake_cnt != '1) wake_cnt <= wake_cnt + 1'b1;
      if (gpd == goff) grp_cnt <= '0;
      else if (grp_cnt != '1) grp_cnt <= grp_cnt + 1'b1;
    end
  end

  assert_sleep_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> $past(quiet));
  assert_sleep_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> !$past(quiet));
  assert_quiet_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet) |-> (quiet == $past(sleep)) && (wake_cnt == WCW'(WAKE_LAT)));
  assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(wake_wr) && $stable(sleep));
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(wake_rd));
  assert_group_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(goff) |-> (goff == $past(gpd)) && (grp_cnt == GCW'(GRP_LAT)));
  assert_group_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpd) |-> $past(pwr_wr && sole_member));
  assert_local_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lpd) |-> $past(pwr_wr) && !$past(grp_busy));
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_busy) |-> $past(pwr_wr));
endmodule

bind rdpw_ctrl rdpw_ctrl_chk #(.WAKE_LAT(WAKE_LAT), .GRP_LAT(GRP_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep       (sleep),
  .quiet       (quiet),
  .err         (err),
  .lpd         (lpd),
  .gpd         (gpd),
  .goff        (goff),
  .grp_busy    (grp_busy),
  .wake_wr     (wake_wr),
  .wake_rd     (wake_rd),
  .pwr_wr      (pwr_wr),
  .sole_member (sole_member)
);

// File: tb/sim_rdpw_ctrl.sv
module sim_rdpw_ctrl;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sole_member = 1'b0;
  logic        grp_busy;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rdpw_ctrl #(.WAKE_LAT(8), .GRP_LAT(16), .AW(AW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sole_member (sole_member),
    .grp_busy    (grp_busy)
  );

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic        sole;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        busy;
    logic [3:0]  req;
  } step_t;

  function automatic step_t mk(input logic [1:0] k, input logic s, input logic [7:0] a,
                               input logic [31:0] d, input logic [31:0] e,
                               input logic b, input logic [3:0] r);
    step_t t;
    t.kind = k; t.sole = s; t.addr = a; t.data = d; t.exp = e; t.busy = b; t.req = r;
    return t;
  endfunction

  // Latencies 8 (wake) and 16 (group); each step takes one cycle, idle takes data cycles
  localparam int NSTEP = 33;
  localparam step_t TBL [NSTEP] = '{
    mk(K_RD,   0, 8'h14, 0,  32'h6, 0, 1),          // R1 reset sleep register
    mk(K_RD,   0, 8'h24, 0,  32'h0, 0, 1),          // R1 reset power register
    mk(K_RD,   0, 8'h30, 0,  32'h0, 0, 2),          // R2 unmapped offset
    mk(K_WR,   0, 8'h14, 32'h4, 0, 0, 3),           // R3 clear sleep, quiet bit RO
    mk(K_IDLE, 0, 8'h00, 7,  0,     0, 3),
    mk(K_RD,   0, 8'h14, 0,  32'h4, 0, 3),          // R3 one cycle before lag ends
    mk(K_RD,   0, 8'h14, 0,  32'h0, 0, 3),          // R3 quiet fell after 8
    mk(K_WR,   0, 8'h14, 32'h0, 0, 0, 5),           // R5 no-change write
    mk(K_RD,   0, 8'h14, 0,  32'h0, 0, 5),          // R5 no error raised
    mk(K_WR,   0, 8'h14, 32'h2, 0, 0, 4),           // R4 set sleep while quiet=0
    mk(K_WR,   0, 8'h14, 32'h0, 0, 0, 5),           // R5 illegal clear while quiet=0
    mk(K_IDLE, 0, 8'h00, 5,  0,     0, 5),
    mk(K_RD,   0, 8'h14, 0,  32'h8000_0002, 0, 5),  // R5 error set, sleep kept
    mk(K_RD,   0, 8'h14, 0,  32'h2, 0, 6),          // R6 cleared by the read
    mk(K_RD,   0, 8'h14, 0,  32'h6, 0, 4),          // R4 quiet rose after 8
    mk(K_WR,   0, 8'h24, 32'h1, 0, 0, 8),           // R8 not last member
    mk(K_RD,   0, 8'h24, 0,  32'h1, 0, 8),
    mk(K_IDLE, 0, 8'h00, 20, 0,     0, 8),
    mk(K_RD,   0, 8'h24, 0,  32'h1, 0, 8),          // R8 group never moves
    mk(K_WR,   0, 8'h24, 32'h6, 0, 0, 2),           // R2 group bits RO
    mk(K_RD,   0, 8'h24, 0,  32'h0, 0, 2),
    mk(K_WR,   1, 8'h24, 32'h1, 0, 0, 7),           // R7 last member powers down
    mk(K_RD,   1, 8'h24, 0,  32'h3, 1, 7),          // R7 R11 window open
    mk(K_WR,   1, 8'h24, 32'h0, 0, 0, 9),           // R9 write during window
    mk(K_RD,   1, 8'h24, 0,  32'h3, 1, 9),          // R9 ignored
    mk(K_IDLE, 1, 8'h00, 12, 0,     0, 7),
    mk(K_RD,   1, 8'h24, 0,  32'h3, 1, 7),          // R7 last cycle of window
    mk(K_RD,   1, 8'h24, 0,  32'h7, 0, 7),          // R7 R11 group off
    mk(K_WR,   1, 8'h24, 32'h0, 0, 0, 10),          // R10 power-on
    mk(K_RD,   1, 8'h24, 0,  32'h4, 1, 10),         // R10 power-up window
    mk(K_IDLE, 1, 8'h00, 14, 0,     0, 10),
    mk(K_RD,   1, 8'h24, 0,  32'h4, 1, 10),         // R10 last cycle of window
    mk(K_RD,   1, 8'h24, 0,  32'h0, 0, 10)          // R10 R11 group back on
  };

  // All tasks start and end on a falling edge
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] e, input logic b,
                         input int r);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    tests++;
    if (bus_rdata !== e || grp_busy !== b) begin
      fails++;
      $display("FAIL R%0d addr %h: actual data %h busy %b, expected data %h busy %b",
               r, a, bus_rdata, grp_busy, e, b);
    end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      sole_member = TBL[i].sole;
      case (TBL[i].kind)
        K_WR:    do_write(TBL[i].addr, TBL[i].data);
        K_RD:    do_read(TBL[i].addr, TBL[i].exp, TBL[i].busy, int'(TBL[i].req));
        default: repeat (int'(TBL[i].data)) @(negedge clk);
      endcase
    end

    // R5: set request while a wake is still settling (sleep 0, quiet 1)
    sole_member = 1'b0;
    do_write(8'h14, 32'h0);
    do_write(8'h14, 32'h2);
    do_read(8'h14, 32'h8000_0004, 1'b0, 5);
    repeat (7) @(negedge clk);
    // R6: error gone after that read; wake settled
    do_read(8'h14, 32'h0, 1'b0, 6);

    // R1: reset from a non-default state
    do_write(8'h24, 32'h1);
    do_write(8'h14, 32'h2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h14, 32'h6, 1'b0, 1);
    do_read(8'h24, 32'h0, 1'b0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule